// File: doc/BRIEF.md
# Three-Phase Gate Command and Overcurrent Response

This block sits between a PWM generator and the gate drivers of a three-phase half-bridge. It produces a high-side and a low-side gate enable for each phase, registered once on the way out. In independent mode every gate follows its own PWM line. In complementary mode only the three high-side lines are used. Each low-side gate is then the inverse of its high-side gate, with a programmable stretch of dead time in which both gates of the phase are low.

Per-phase overcurrent strobes and an overtemperature strobe drive the protection path. A two-bit policy field chooses one of four responses. In limiting mode only the offending phase is switched off. It recovers either at the next PWM period start or after a fixed off time. In latched mode all six gates go off until a fault-clear pulse, and a one-cycle shutdown event goes to a status block. Report-only mode leaves the gates alone. Disabled mode ignores the strobes completely. An active-low warning output combines the overtemperature and overcurrent indications according to a selection field.

Top module: `gate_oc_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all six gate enables are 0, `warn_n` is 1 and `oc_shut_evt` is 0.
- R2: With `pwm_mode`=0, a gate rises one cycle after its PWM line rises. Each gate follows its own line. If a phase requests both sides high, both gates of that phase stay low.
- R3: With `pwm_mode`=1, `pwm_lo` is ignored and the low gate of a phase is the complement of its high gate. On every switch between sides, both gates stay low for DEAD_CYC cycles before the new side rises.
- R4: The high and low gate of a phase are never high at the same time, in any mode.
- R5: With `oc_mode`=00 (limit) and `toff_mode`=0, an overcurrent strobe on phase p drives both gates of p low at the next edge. The other phases are unaffected. Gates of p resume one cycle after the edge that samples `cycle_start`.
- R6: With `oc_mode`=00 and `toff_mode`=1, the struck phase stays low for TOFF_CYC+1 cycles after the detecting edge and then resumes. `cycle_start` has no effect on this.
- R7: With `oc_mode`=01 (latched), any strobe drives all six gates low at the next edge. They stay low until the edge after `fault_clr` is sampled, and then resume.
- R8: With `oc_mode`=10 (report), strobes do not change the gates but do assert the warning.
- R9: With `oc_mode`=11 (disabled), strobes change neither the gates nor the warning.
- R10: `warn_n` is low for the cycle after a reported event. With `warn_sel`=00 both overtemperature and overcurrent report. With 01 only overtemperature reports. With 10 or 11 only overcurrent reports.
- R11: `oc_shut_evt` is a single-cycle pulse, raised at the same edge as the latched shutdown and only in latched mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_hi | input | 3 | High-side PWM request per phase |
| pwm_lo | input | 3 | Low-side PWM request per phase (independent mode only) |
| oc_det | input | 3 | Per-phase overcurrent strobe |
| ot_warn | input | 1 | Overtemperature warning strobe |
| cycle_start | input | 1 | PWM period start pulse |
| fault_clr | input | 1 | Clears a latched shutdown |
| pwm_mode | input | 1 | 0 independent, 1 complementary |
| oc_mode | input | 2 | 00 limit, 01 latched, 10 report, 11 disabled |
| toff_mode | input | 1 | 0 recover at period start, 1 fixed off time |
| warn_sel | input | 2 | Warning source selection |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| warn_n | output | 1 | Active-low combined warning |
| oc_shut_evt | output | 1 | Latched-shutdown event pulse |

## Verification
The hardest situation to reach is the moment a phase leaves protection in complementary mode. Blanking release, the dead-time counter and the new side's request all meet in that cycle. The stimulus keeps the outputs settled, issues a single-phase strobe, and then holds off the release pulse for several cycles. Each gate is then sampled at the exact edge where it must stay low and at the edge where it must rise. The fixed off time is checked the same way, with a period-start pulse placed inside the window to show that it is ignored.

// File: rtl/gate_oc_pkg.sv
// Shared encodings for the gate command and overcurrent response block.
package gate_oc_pkg;
    typedef enum logic [1:0] {
        OC_LIMIT  = 2'b00,
        OC_LATCH  = 2'b01,
        OC_REPORT = 2'b10,
        OC_OFF    = 2'b11
    } oc_mode_e;

    typedef enum logic [1:0] {
        WSEL_BOTH   = 2'b00,
        WSEL_OT     = 2'b01,
        WSEL_OC     = 2'b10,
        WSEL_OC_ALT = 2'b11
    } warn_sel_e;
endpackage

// File: rtl/oc_limit_phase.sv
// Per-phase current-limit blanking.
// Raises blank on an overcurrent strobe while limiting is enabled.
// Releases blank at the next period start (toff_mode=0) or after TOFF_CYC
// further cycles (toff_mode=1).
// Assumes TOFF_CYC >= 1. A new strobe while blanked restarts the window.
module oc_limit_phase #(
    parameter int TOFF_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic limit_en,
    input  logic toff_mode,
    input  logic det,
    input  logic cycle_start,
    output logic blank
);
    localparam int CNT_W = $clog2(TOFF_CYC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             blank_q;

    // Blank flag and off-time counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!limit_en) begin
            blank_q <= 1'b0;
            cnt_q   <= '0;
        end else if (det) begin
            blank_q <= 1'b1;
            cnt_q   <= CNT_W'(TOFF_CYC - 1);
        end else if (blank_q) begin
            if (toff_mode) begin
                if (cnt_q == '0) blank_q <= 1'b0;
                else             cnt_q   <= cnt_q - 1'b1;
            end else if (cycle_start) begin
                blank_q <= 1'b0;
            end
        end
    end

    assign blank = blank_q;

    a_r5_cbc_release: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_en && !toff_mode && blank_q && cycle_start && !det) |=> !blank_q);
    a_r8_no_blank_outside_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !limit_en |=> !blank_q);
    a_r6_strobe_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_en && det) |=> blank_q);
endmodule

// File: rtl/oc_latch.sv
// Latched overcurrent shutdown with a one-cycle event pulse.
// A strobe in latched mode sets the shutdown. Only fault_clr clears it, and a
// strobe in the same cycle wins over the clear.
module oc_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_en,
    input  logic any_det,
    input  logic fault_clr,
    output logic shut,
    output logic evt
);
    logic shut_q, evt_q;

    // Shutdown latch and rising-edge event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_q <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            evt_q <= latch_en && any_det && !shut_q;
            if (latch_en && any_det) shut_q <= 1'b1;
            else if (fault_clr)      shut_q <= 1'b0;
        end
    end

    assign shut = shut_q;
    assign evt  = evt_q;

    a_r11_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |=> !evt_q);
    a_r11_evt_with_shut: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> shut_q);
endmodule

// File: rtl/gate_phase.sv
// One half-bridge leg: picks the requested side, applies the kill input and,
// in complementary mode, waits DEAD_CYC idle cycles before a side rises.
// Outputs are registered. A direct swap in independent mode still passes
// through one cycle with both gates low.
// Assumes DEAD_CYC >= 1.
module gate_phase #(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_mode,
    input  logic req_hi,
    input  logic req_lo,
    input  logic kill,
    output logic gh,
    output logic gl
);
    localparam int DT_W = $clog2(DEAD_CYC + 1);

    logic            gh_q, gl_q;
    logic [DT_W-1:0] idle_q;
    logic            idle_ok, tgt_hi, tgt_lo, nxt_hi, nxt_lo;

    // Select target side and gate it against the opposite side and dead time.
    always_comb begin
        idle_ok = (idle_q >= DT_W'(DEAD_CYC));
        tgt_hi  = !kill && (pwm_mode ? req_hi  : (req_hi && !req_lo));
        tgt_lo  = !kill && (pwm_mode ? !req_hi : (req_lo && !req_hi));
        nxt_hi  = tgt_hi && !gl_q && (gh_q || !pwm_mode || idle_ok);
        nxt_lo  = tgt_lo && !gh_q && (gl_q || !pwm_mode || idle_ok);
    end

    // Gate registers and saturating idle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gh_q   <= 1'b0;
            gl_q   <= 1'b0;
            idle_q <= '0;
        end else begin
            gh_q <= nxt_hi;
            gl_q <= nxt_lo;
            if (nxt_hi || nxt_lo) idle_q <= '0;
            else if (!idle_ok)    idle_q <= idle_q + 1'b1;
        end
    end

    assign gh = gh_q;
    assign gl = gl_q;

    a_r4_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(gh_q && gl_q));
    a_r3_dead_before_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && $rose(gl_q)) |-> $past(!gh_q));
    a_r3_dead_before_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode && $rose(gh_q)) |-> $past(!gl_q));
endmodule

// File: rtl/warn_gen.sv
// Registered active-low warning. Combines the overtemperature and overcurrent
// strobes according to the selection field.
module warn_gen
    import gate_oc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ot,
    input  logic      oc,
    input  warn_sel_e sel,
    output logic      warn_n
);
    logic use_ot, use_oc, warn_q;

    // Decode which sources may drive the warning.
    always_comb begin
        use_ot = (sel == WSEL_BOTH) || (sel == WSEL_OT);
        use_oc = (sel != WSEL_OT);
    end

    // Output register, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) warn_q <= 1'b1;
        else        warn_q <= !((ot && use_ot) || (oc && use_oc));
    end

    assign warn_n = warn_q;

    a_r10_ot_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc && sel inside {WSEL_OC, WSEL_OC_ALT}) |=> warn_q);
endmodule

// File: rtl/gate_oc_ctrl.sv
// Top level: three gate legs, per-phase limit blanking, the shutdown latch
// and the warning output. Overcurrent strobes act on the gates at the edge
// where they are sampled, and the registered protection state holds them off
// from then on.
module gate_oc_ctrl
    import gate_oc_pkg::*;
#(
    parameter int NPH      = 3,
    parameter int DEAD_CYC = 4,
    parameter int TOFF_CYC = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] pwm_hi,
    input  logic [NPH-1:0] pwm_lo,
    input  logic [NPH-1:0] oc_det,
    input  logic           ot_warn,
    input  logic           cycle_start,
    input  logic           fault_clr,
    input  logic           pwm_mode,
    input  logic [1:0]     oc_mode,
    input  logic           toff_mode,
    input  logic [1:0]     warn_sel,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo,
    output logic           warn_n,
    output logic           oc_shut_evt
);
    oc_mode_e       mode;
    logic           limit_en, latch_en, any_det, shut;
    logic [NPH-1:0] det_eff, blank, kill;

    // Decode policy and mask strobes when protection is disabled.
    always_comb begin
        mode     = oc_mode_e'(oc_mode);
        limit_en = (mode == OC_LIMIT);
        latch_en = (mode == OC_LATCH);
        det_eff  = (mode == OC_OFF) ? '0 : oc_det;
        any_det  = |det_eff;
        for (int p = 0; p < NPH; p++)
            kill[p] = blank[p] || (limit_en && det_eff[p]) || shut || (latch_en && any_det);
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        oc_limit_phase #(.TOFF_CYC(TOFF_CYC)) u_limit (
            .clk(clk), .rst_n(rst_n), .limit_en(limit_en), .toff_mode(toff_mode),
            .det(det_eff[p]), .cycle_start(cycle_start), .blank(blank[p])
        );
        gate_phase #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .req_hi(pwm_hi[p]),
            .req_lo(pwm_lo[p]), .kill(kill[p]), .gh(gate_hi[p]), .gl(gate_lo[p])
        );
    end

    oc_latch u_latch (
        .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .any_det(any_det),
        .fault_clr(fault_clr), .shut(shut), .evt(oc_shut_evt)
    );

    warn_gen u_warn (
        .clk(clk), .rst_n(rst_n), .ot(ot_warn), .oc(any_det),
        .sel(warn_sel_e'(warn_sel)), .warn_n(warn_n)
    );

    a_r7_latched_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        shut |=> (gate_hi == '0 && gate_lo == '0));
    a_r9_disabled_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OC_OFF && !ot_warn) |=> warn_n);
    a_r11_evt_only_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> !oc_shut_evt);
endmodule

// File: tb/tb_gate_oc_ctrl.sv
module tb_gate_oc_ctrl;
    localparam int DT = 4;
    localparam int TF = 16;

    logic clk = 0, rst_n = 0;
    logic [2:0] pwm_hi = 0, pwm_lo = 0, oc_det = 0;
    logic ot_warn = 0, cycle_start = 0, fault_clr = 0, pwm_mode = 0, toff_mode = 0;
    logic [1:0] oc_mode = 2'b00, warn_sel = 2'b00;
    logic [2:0] gate_hi, gate_lo;
    logic warn_n, oc_shut_evt;
    int checks = 0, fails = 0, shoot = 0;

    always #4 clk = ~clk;

    gate_oc_ctrl #(.NPH(3), .DEAD_CYC(DT), .TOFF_CYC(TF)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .oc_det(oc_det),
        .ot_warn(ot_warn), .cycle_start(cycle_start), .fault_clr(fault_clr),
        .pwm_mode(pwm_mode), .oc_mode(oc_mode), .toff_mode(toff_mode),
        .warn_sel(warn_sel), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .warn_n(warn_n), .oc_shut_evt(oc_shut_evt)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // R4 monitor, sampled between edges
    always @(negedge clk) if (rst_n && ((gate_hi & gate_lo) != 0)) shoot++;

    task automatic t_reset();
        tick(2);
        chk("R1 hi in reset", gate_hi, 0);
        chk("R1 lo in reset", gate_lo, 0);
        chk("R1 warn in reset", warn_n, 1);
        rst_n = 1; pwm_hi = 3'b111;
        chk("R1 evt", oc_shut_evt, 0);
        tick();
        chk("R1 hi after reset", gate_hi, 3'b111);
        pwm_hi = 0; tick(2);
    endtask

    task automatic t_mode0();
        pwm_mode = 0; pwm_hi = 3'b101; pwm_lo = 3'b010; tick();
        chk("R2 hi follow", gate_hi, 3'b101);
        chk("R2 lo follow", gate_lo, 3'b010);
        pwm_hi = 3'b011; pwm_lo = 3'b100; tick(2);
        chk("R2 hi pattern2", gate_hi, 3'b011);
        chk("R2 lo pattern2", gate_lo, 3'b100);
        pwm_hi = 3'b001; pwm_lo = 3'b001; tick(2);
        chk("R2 both requested hi", gate_hi, 0);
        chk("R2 both requested lo", gate_lo, 0);
    endtask

    task automatic t_mode1();
        pwm_mode = 1; pwm_hi = 0; pwm_lo = 3'b111; tick(10);
        chk("R3 complement low", gate_lo, 3'b111);
        chk("R3 complement high", gate_hi, 0);
        pwm_hi = 3'b001; pwm_lo = 3'b000;
        for (int i = 0; i < DT; i++) begin
            tick();
            chk("R3 dead hi", gate_hi[0], 0);
            chk("R3 dead lo", gate_lo[0], 0);
        end
        tick();
        chk("R3 hi after dead", gate_hi, 3'b001);
        chk("R3 other lows", gate_lo, 3'b110);
        pwm_hi = 0;
        for (int i = 0; i < DT; i++) begin
            tick();
            chk("R3 dead back lo", gate_lo[0], 0);
        end
        tick();
        chk("R3 lo after dead", gate_lo, 3'b111);
    endtask

    task automatic settle_hi();
        pwm_mode = 0; pwm_hi = 3'b111; pwm_lo = 0; oc_det = 0; tick(3);
    endtask

    task automatic t_cbc();
        oc_mode = 2'b00; toff_mode = 0; warn_sel = 2'b00; settle_hi();
        oc_det = 3'b010; tick(); oc_det = 0;
        chk("R5 phase off", gate_hi, 3'b101);
        chk("R10 oc warn both", warn_n, 0);
        tick(3);
        chk("R5 holds until period", gate_hi, 3'b101);
        cycle_start = 1; tick(); cycle_start = 0;
        chk("R5 still off at release edge", gate_hi, 3'b101);
        tick();
        chk("R5 recovered", gate_hi, 3'b111);
    endtask

    task automatic t_toff();
        oc_mode = 2'b00; toff_mode = 1; settle_hi();
        oc_det = 3'b001; tick(); oc_det = 0;
        for (int i = 1; i <= TF; i++) begin
            cycle_start = (i == 3);
            tick();
            if (i == TF || i == 4) chk("R6 off window", gate_hi, 3'b110);
        end
        cycle_start = 0;
        tick();
        chk("R6 recovered after window", gate_hi, 3'b111);
        toff_mode = 0;
    endtask

    task automatic t_latched();
        int evts = 0;
        oc_mode = 2'b01; settle_hi();
        oc_det = 3'b100; tick(); oc_det = 0;
        chk("R7 all off", {gate_hi, gate_lo}, 0);
        chk("R11 event pulse", oc_shut_evt, 1);
        for (int i = 0; i < 6; i++) begin
            tick(); evts += oc_shut_evt;
        end
        chk("R11 single pulse", evts, 0);
        chk("R7 still off", gate_hi, 0);
        fault_clr = 1; tick(); fault_clr = 0;
        tick();
        chk("R7 resume after clear", gate_hi, 3'b111);
    endtask

    task automatic t_report();
        oc_mode = 2'b10; warn_sel = 2'b00; settle_hi();
        oc_det = 3'b111; tick(); oc_det = 0;
        chk("R8 gates unchanged", gate_hi, 3'b111);
        chk("R8 warning", warn_n, 0);
        chk("R11 no event in report", oc_shut_evt, 0);
        tick();
        chk("R8 warn releases", warn_n, 1);
    endtask

    task automatic t_disabled();
        oc_mode = 2'b11; settle_hi();
        oc_det = 3'b111; tick(); oc_det = 0;
        chk("R9 gates unchanged", gate_hi, 3'b111);
        chk("R9 no warning", warn_n, 1);
        chk("R9 no event", oc_shut_evt, 0);
    endtask

    task automatic t_warn();
        oc_mode = 2'b10;
        for (int s = 0; s < 4; s++) begin
            warn_sel = 2'(s);
            ot_warn = 1; tick(); ot_warn = 0;
            chk("R10 ot strobe", warn_n, (s < 2) ? 0 : 1);
            tick();
            oc_det = 3'b010; tick(); oc_det = 0;
            chk("R10 oc strobe", warn_n, (s == 1) ? 1 : 0);
            tick();
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick();
        t_reset();
        t_mode0();
        t_mode1();
        t_cbc();
        t_toff();
        t_latched();
        t_report();
        t_disabled();
        t_warn();
        chk("R4 never both high", shoot, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule